// File: doc/BRIEF.md
# Receive-to-Transmit Loopback with Address Rewrite

This block sits between the receive and transmit streaming ports of a 10G Ethernet MAC and sends every good frame back out on the same channel. Incoming beats are collected in an internal frame store. A frame becomes visible to the transmit side only after its final beat has arrived with a good indication. On the way out, the first twelve bytes of each frame are overwritten with a destination and a source MAC address. Both addresses are fixed by parameters.

The receive side cannot be back-pressured, so arrival can outrun departure. When the store has no room for an arriving beat, the frame in progress is abandoned as a whole, and a saturating counter of lost frames advances. Looping is enabled by a mode input that selects the external traffic source. A PHY link indication is passed through to a status output next to the drop count. Everything runs on one clock.

Top module: `frame_loopback_swap`

## Requirements
- R1: Every good frame is sent on the transmit stream in arrival order. Data beyond the header bytes, tkeep and tlast are unchanged. One beat moves on each cycle where tx_tvalid and tx_tready are both high.
- R2: Byte n of a frame, for n below 12, is replaced. Byte n is the beat-relative byte (n mod bytes-per-beat) of beat (n div bytes-per-beat), where byte 0 is bits [7:0]. Bytes 0..5 carry DST_MAC, most significant byte first. Bytes 6..11 carry SRC_MAC in the same order.
- R3: tx_tvalid stays low until the last beat of a frame has been stored and marked good. It is low whenever no complete frame is waiting.
- R4: A frame whose last beat carries rx_tuser low is removed from the store entirely and never transmitted.
- R5: A frame whose first beat arrives while ext_mode_i is low is ignored completely, even if the mode rises before its last beat. It does not count as a drop. Frames already stored still drain.
- R6: When a beat arrives while the store holds DEPTH entries, counting the unfinished frame, the whole frame is dropped. This includes its beats already stored. Its remaining beats are ignored.
- R7: drop_count_o is 0 after reset and rises by exactly one for each frame dropped under R6.
- R8: drop_count_o holds at its all-ones value and does not wrap.
- R9: phy_up_o equals phy_up_i delayed by one clock.
- R10: While tx_tvalid is high and tx_tready is low, tx_tvalid, tx_tdata, tx_tkeep and tx_tlast hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | High selects external-traffic loopback |
| phy_up_i | input | 1 | PHY link up indication |
| rx_tdata_i | input | DATA_W | Receive stream data |
| rx_tkeep_i | input | DATA_W/8 | Receive byte enables |
| rx_tvalid_i | input | 1 | Receive beat valid |
| rx_tlast_i | input | 1 | Receive end of frame |
| rx_tuser_i | input | 1 | Frame good, sampled with rx_tlast_i |
| tx_tdata_o | output | DATA_W | Transmit stream data |
| tx_tkeep_o | output | DATA_W/8 | Transmit byte enables |
| tx_tlast_o | output | 1 | Transmit end of frame |
| tx_tvalid_o | output | 1 | Transmit beat valid |
| tx_tready_i | input | 1 | Transmit ready |
| phy_up_o | output | 1 | Registered PHY link status |
| drop_count_o | output | CNT_W | Saturating count of overflowed frames |

## Verification
Directed frames with an always-ready sink show the header substitution and the untouched payload, free of any timing interference. Bad frames and frames that begin in the wrong mode must leave the output idle and the count unchanged. A stalled sink that fills the store separates whole-frame rollback from partial forwarding, and a long run of stalled frames shows that the counter saturates instead of wrapping. Randomised lengths, gaps, good flags and ready patterns then mix commits, rollbacks and overflows against a bench model of store occupancy.

// File: rtl/lb_pkg.sv
package lb_pkg;

  typedef enum logic [1:0] {
    ING_IDLE  = 2'd0,
    ING_STORE = 2'd1,
    ING_DROP  = 2'd2
  } ing_state_e;

  localparam int unsigned HDR_BYTES = 12;

  // Header byte n: destination address first, then source, MSB first.
  function automatic logic [7:0] hdr_byte(input logic [47:0] dst,
                                          input logic [47:0] src,
                                          input int unsigned n);
    logic [7:0] b;
    if (n < 6) b = dst[8*(5-n) +: 8];
    else       b = src[8*(11-n) +: 8];
    return b;
  endfunction

endpackage

// File: rtl/lb_frame_store.sv
module lb_frame_store #(
  parameter int W     = 73,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         commit,
  input  logic         rollback,
  input  logic         rd_pop,
  output logic         full,
  output logic         rd_valid,
  output logic [W-1:0] rd_word
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_n;
  logic [PW-1:0] wr_cmt, wr_cmt_n;
  logic [PW-1:0] rd_ptr, rd_ptr_n;

  assign full     = (wr_ptr - rd_ptr) == PW'(DEPTH);
  assign rd_valid = (rd_ptr != wr_cmt);
  assign rd_word  = mem[rd_ptr[AW-1:0]];

  always_comb begin
    wr_ptr_n = wr_ptr;
    wr_cmt_n = wr_cmt;
    rd_ptr_n = rd_ptr;
    if (rollback) begin
      wr_ptr_n = wr_cmt;
    end else if (wr_en) begin
      wr_ptr_n = wr_ptr + PW'(1);
      if (commit) wr_cmt_n = wr_ptr + PW'(1);
    end
    if (rd_pop && rd_valid) rd_ptr_n = rd_ptr + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      wr_cmt <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      wr_cmt <= wr_cmt_n;
      rd_ptr <= rd_ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rollback) mem[wr_ptr[AW-1:0]] <= wr_word;
  end

endmodule

// File: rtl/lb_ingress_ctrl.sv
module lb_ingress_ctrl
  import lb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_ext,
  input  logic beat_valid,
  input  logic beat_last,
  input  logic beat_good,
  input  logic store_full,
  output logic wr_en,
  output logic commit,
  output logic rollback,
  output logic drop_pulse
);
  ing_state_e state, state_n;

  always_comb begin
    state_n    = state;
    wr_en      = 1'b0;
    commit     = 1'b0;
    rollback   = 1'b0;
    drop_pulse = 1'b0;
    if (beat_valid) begin
      if (state == ING_DROP) begin
        if (beat_last) state_n = ING_IDLE;
      end else if (state == ING_IDLE && !mode_ext) begin
        state_n = beat_last ? ING_IDLE : ING_DROP;
      end else if (store_full) begin
        rollback   = 1'b1;
        drop_pulse = 1'b1;
        state_n    = beat_last ? ING_IDLE : ING_DROP;
      end else if (beat_last && !beat_good) begin
        rollback = 1'b1;
        state_n  = ING_IDLE;
      end else begin
        wr_en   = 1'b1;
        commit  = beat_last;
        state_n = beat_last ? ING_IDLE : ING_STORE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ING_IDLE;
    else        state <= state_n;
  end

endmodule

// File: rtl/lb_header_rewrite.sv
module lb_header_rewrite
  import lb_pkg::*;
#(
  parameter int          DATA_W  = 64,
  parameter logic [47:0] DST_MAC = 48'h0,
  parameter logic [47:0] SRC_MAC = 48'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_take,
  input  logic              beat_last,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out
);
  localparam int BYTES     = DATA_W / 8;
  localparam int HDR_BEATS = (HDR_BYTES + BYTES - 1) / BYTES;
  localparam int IW        = $clog2(HDR_BEATS + 1);

  logic [IW-1:0] beat_idx, beat_idx_n;

  always_comb begin
    beat_idx_n = beat_idx;
    if (beat_take) begin
      if (beat_last)                       beat_idx_n = '0;
      else if (beat_idx != IW'(HDR_BEATS)) beat_idx_n = beat_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_idx <= '0;
    else        beat_idx <= beat_idx_n;
  end

  always_comb begin
    data_out = data_in;
    for (int k = 0; k < BYTES; k++) begin
      int unsigned off;
      off = int'(beat_idx) * BYTES + k;
      if (off < HDR_BYTES) data_out[8*k +: 8] = hdr_byte(DST_MAC, SRC_MAC, off);
    end
  end

endmodule

// File: rtl/lb_drop_counter.sv
module lb_drop_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic             cnt_en;
  logic [CNT_W-1:0] count_n;

  assign cnt_en  = inc && !(&count);
  assign count_n = count + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= count_n;
  end

endmodule

// File: rtl/frame_loopback_swap.sv
module frame_loopback_swap #(
  parameter int          DATA_W  = 64,
  parameter int          DEPTH   = 32,
  parameter int          CNT_W   = 16,
  parameter logic [47:0] DST_MAC = 48'h02_11_22_33_44_55,
  parameter logic [47:0] SRC_MAC = 48'h02_66_77_88_99_AA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_mode_i,
  input  logic                phy_up_i,
  input  logic [DATA_W-1:0]   rx_tdata_i,
  input  logic [DATA_W/8-1:0] rx_tkeep_i,
  input  logic                rx_tvalid_i,
  input  logic                rx_tlast_i,
  input  logic                rx_tuser_i,
  output logic [DATA_W-1:0]   tx_tdata_o,
  output logic [DATA_W/8-1:0] tx_tkeep_o,
  output logic                tx_tlast_o,
  output logic                tx_tvalid_o,
  input  logic                tx_tready_i,
  output logic                phy_up_o,
  output logic [CNT_W-1:0]    drop_count_o
);
  localparam int KW = DATA_W / 8;
  localparam int EW = DATA_W + KW + 1;

  logic [1:0]  rst_sync;
  logic        rst_s;
  logic        wr_en, commit, rollback, drop_pulse, full, rd_valid, pop;
  logic [EW-1:0] rd_word;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  lb_ingress_ctrl u_ing (
    .clk        (clk),
    .rst_n      (rst_s),
    .mode_ext   (ext_mode_i),
    .beat_valid (rx_tvalid_i),
    .beat_last  (rx_tlast_i),
    .beat_good  (rx_tuser_i),
    .store_full (full),
    .wr_en      (wr_en),
    .commit     (commit),
    .rollback   (rollback),
    .drop_pulse (drop_pulse)
  );

  lb_frame_store #(.W(EW), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en    (wr_en),
    .wr_word  ({rx_tlast_i, rx_tkeep_i, rx_tdata_i}),
    .commit   (commit),
    .rollback (rollback),
    .rd_pop   (pop),
    .full     (full),
    .rd_valid (rd_valid),
    .rd_word  (rd_word)
  );

  assign pop         = rd_valid && tx_tready_i;
  assign tx_tvalid_o = rd_valid;
  assign tx_tlast_o  = rd_word[EW-1];
  assign tx_tkeep_o  = rd_word[DATA_W +: KW];

  lb_header_rewrite #(.DATA_W(DATA_W), .DST_MAC(DST_MAC), .SRC_MAC(SRC_MAC)) u_hdr (
    .clk       (clk),
    .rst_n     (rst_s),
    .beat_take (pop),
    .beat_last (rd_word[EW-1]),
    .data_in   (rd_word[DATA_W-1:0]),
    .data_out  (tx_tdata_o)
  );

  lb_drop_counter #(.CNT_W(CNT_W)) u_drop (
    .clk   (clk),
    .rst_n (rst_s),
    .inc   (drop_pulse),
    .count (drop_count_o)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) phy_up_o <= 1'b0;
    else        phy_up_o <= phy_up_i;
  end

endmodule

// File: rtl/frame_loopback_swap_chk.sv
module frame_loopback_swap_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input logic                clk,
  input logic                rst_s,
  input logic                phy_up_i,
  input logic                phy_up_o,
  input logic [DATA_W-1:0]   tx_tdata_o,
  input logic [DATA_W/8-1:0] tx_tkeep_o,
  input logic                tx_tlast_o,
  input logic                tx_tvalid_o,
  input logic                tx_tready_i,
  input logic [CNT_W-1:0]    drop_count_o
);
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_s)
    tx_tvalid_o && !tx_tready_i |=> tx_tvalid_o && $stable(tx_tdata_o)
      && $stable(tx_tkeep_o) && $stable(tx_tlast_o));

  p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (drop_count_o == $past(drop_count_o))
          || (drop_count_o == $past(drop_count_o) + CNT_W'(1)));

  p_drop_sat_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (&drop_count_o) |=> (&drop_count_o));

  p_phy_follow_r9: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> phy_up_o == $past(phy_up_i));

endmodule

bind frame_loopback_swap frame_loopback_swap_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_s        (rst_s),
  .phy_up_i     (phy_up_i),
  .phy_up_o     (phy_up_o),
  .tx_tdata_o   (tx_tdata_o),
  .tx_tkeep_o   (tx_tkeep_o),
  .tx_tlast_o   (tx_tlast_o),
  .tx_tvalid_o  (tx_tvalid_o),
  .tx_tready_i  (tx_tready_i),
  .drop_count_o (drop_count_o)
);

// File: tb/frame_loopback_swap_tb_top.sv
module frame_loopback_swap_tb_top;
  localparam int          DW    = 64;
  localparam int          KW    = 8;
  localparam int          DEPTH = 16;
  localparam int          CW    = 4;
  localparam logic [47:0] DA    = 48'hA1_B2_C3_D4_E5_F6;
  localparam logic [47:0] SA    = 48'h10_20_30_40_50_60;
  localparam int          MAXC  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n, ext_mode, phy_in, rx_valid, rx_last, rx_user, tx_ready;
  logic [DW-1:0] rx_data;
  logic [KW-1:0] rx_keep;
  logic [DW-1:0] tx_data;
  logic [KW-1:0] tx_keep;
  logic tx_last, tx_valid, phy_out;
  logic [CW-1:0] drops;

  always #5 clk = ~clk;

  frame_loopback_swap #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW),
                        .DST_MAC(DA), .SRC_MAC(SA)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode), .phy_up_i(phy_in),
    .rx_tdata_i(rx_data), .rx_tkeep_i(rx_keep), .rx_tvalid_i(rx_valid),
    .rx_tlast_i(rx_last), .rx_tuser_i(rx_user),
    .tx_tdata_o(tx_data), .tx_tkeep_o(tx_keep), .tx_tlast_o(tx_last),
    .tx_tvalid_o(tx_valid), .tx_tready_i(tx_ready),
    .phy_up_o(phy_out), .drop_count_o(drops));

  int checks = 0, failures = 0;
  int rdy_mode = 1;
  int m_state = 0;
  int m_drops = 0;
  logic [DW-1:0] exp_d[$], cur_d[$];
  logic [KW-1:0] exp_k[$], cur_k[$];
  logic          exp_l[$], cur_l[$];
  logic          stall_prev = 1'b0;
  logic [DW-1:0] stall_d;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] swap_hdr(input logic [DW-1:0] d, input int beat);
    logic [95:0] h;
    logic [DW-1:0] r;
    h = {DA, SA};
    r = d;
    for (int k = 0; k < KW; k++) begin
      int pos;
      pos = beat * KW + k;
      if (pos < 12) r[8*k +: 8] = h[8*(11-pos) +: 8];
    end
    return r;
  endfunction

  // One cycle: entered at a falling edge with rx inputs driven.
  task automatic tick();
    bit full;
    case (rdy_mode)
      0: tx_ready = 1'b0;
      1: tx_ready = 1'b1;
      default: tx_ready = ($urandom % 3) != 0;
    endcase
    #1;
    full = (exp_d.size() + cur_d.size()) == DEPTH;
    // R3: a beat is offered exactly when a complete good frame waits
    chk(tx_valid == (exp_d.size() != 0), "R3 tvalid", 64'(tx_valid), 64'(exp_d.size() != 0));
    if (stall_prev) // R10
      chk(tx_valid && tx_data == stall_d, "R10 hold", tx_data, stall_d);
    stall_prev = tx_valid && !tx_ready;
    stall_d    = tx_data;
    if (tx_valid && tx_ready && exp_d.size() != 0) begin
      chk(tx_data == exp_d[0], "R1/R2 data", tx_data, exp_d[0]);
      chk(tx_keep == exp_k[0] && tx_last == exp_l[0], "R1 keep/last",
          {tx_keep, 7'd0, tx_last}, {exp_k[0], 7'd0, exp_l[0]});
      void'(exp_d.pop_front()); void'(exp_k.pop_front()); void'(exp_l.pop_front());
    end
    if (rx_valid) begin
      if (m_state == 2) begin
        if (rx_last) m_state = 0;
      end else if (m_state == 0 && !ext_mode) begin
        if (!rx_last) m_state = 2;
      end else if (full) begin
        cur_d.delete(); cur_k.delete(); cur_l.delete();
        if (m_drops < MAXC) m_drops++;
        m_state = rx_last ? 0 : 2;
      end else if (rx_last && !rx_user) begin
        cur_d.delete(); cur_k.delete(); cur_l.delete();
        m_state = 0;
      end else begin
        cur_d.push_back(rx_data); cur_k.push_back(rx_keep); cur_l.push_back(rx_last);
        if (rx_last) begin
          for (int i = 0; i < cur_d.size(); i++) begin
            exp_d.push_back(swap_hdr(cur_d[i], i));
            exp_k.push_back(cur_k[i]);
            exp_l.push_back(cur_l[i]);
          end
          cur_d.delete(); cur_k.delete(); cur_l.delete();
          m_state = 0;
        end else m_state = 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    rx_valid = 1'b0; rx_last = 1'b0; rx_user = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send_frame(input int nb, input bit good, input int gap);
    for (int b = 0; b < nb; b++) begin
      rx_valid = 1'b1;
      rx_data  = {$urandom, $urandom};
      rx_last  = (b == nb - 1);
      rx_keep  = rx_last ? KW'((1 << (1 + $urandom % KW)) - 1) : '1;
      rx_user  = rx_last ? good : 1'($urandom);
      tick();
    end
    idle(gap);
  endtask

  task automatic chk_drops(input string tag);
    chk(drops == CW'(m_drops), tag, 64'(drops), 64'(m_drops));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ext_mode = 1'b1; phy_in = 1'b0; tx_ready = 1'b1;
    rx_valid = 1'b0; rx_last = 1'b0; rx_user = 1'b0; rx_data = '0; rx_keep = '0;
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R3 reset tvalid", 64'(tx_valid), 0);
    chk(drops == '0, "R7 reset count", 64'(drops), 0);
    chk(phy_out == 1'b0, "R9 reset phy", 64'(phy_out), 0);
    rst_n = 1'b1;
    idle(4);

    // R9 pass-through with one clock delay
    phy_in = 1'b1; idle(1);
    chk(phy_out == 1'b1, "R9 rise", 64'(phy_out), 1);
    phy_in = 1'b0; idle(1);
    chk(phy_out == 1'b0, "R9 fall", 64'(phy_out), 0);
    phy_in = 1'b1;

    // R1 R2: directed good frames, sink always ready
    rdy_mode = 1;
    send_frame(4, 1'b1, 6);
    send_frame(1, 1'b1, 4);
    send_frame(2, 1'b1, 4);
    // R4: bad frame leaves nothing
    send_frame(5, 1'b0, 6);
    chk(tx_valid == 1'b0, "R4 bad frame", 64'(tx_valid), 0);
    chk_drops("R7 no drop for bad");
    // R5: mode low at first beat, raised mid-frame
    ext_mode = 1'b0;
    rx_valid = 1'b1; rx_last = 1'b0; rx_keep = '1; rx_data = {$urandom, $urandom}; tick();
    ext_mode = 1'b1;
    send_frame(3, 1'b1, 6);
    chk(tx_valid == 1'b0 && drops == CW'(m_drops), "R5 mode ignore", 64'(tx_valid), 0);
    // R5: stored frames still drain after mode drops
    rdy_mode = 0;
    send_frame(3, 1'b1, 2);
    ext_mode = 1'b0; rdy_mode = 1;
    send_frame(2, 1'b1, 8);
    ext_mode = 1'b1;

    // R6 R7: stalled sink, overflow part way through a frame
    rdy_mode = 0;
    send_frame(10, 1'b1, 1);
    send_frame(9, 1'b1, 1);
    chk_drops("R7 one drop");
    chk(drops == CW'(1), "R6 overflow count", 64'(drops), 1);
    rdy_mode = 1;
    idle(DEPTH + 4);

    // Random mix
    for (int f = 0; f < 80; f++) begin
      rdy_mode = 2;
      ext_mode = ($urandom % 8) != 0;
      send_frame(1 + $urandom % 9, ($urandom % 4) != 0, $urandom % 4);
      chk_drops("R7 random");
    end
    ext_mode = 1'b1; rdy_mode = 1;
    idle(DEPTH * 3);

    // R8: saturation
    rdy_mode = 0;
    send_frame(DEPTH, 1'b1, 1);
    for (int f = 0; f < MAXC + 4; f++) send_frame(2, 1'b1, 1);
    chk(drops == CW'(MAXC), "R8 saturate", 64'(drops), 64'(MAXC));
    rdy_mode = 1;
    idle(DEPTH * 3);

    chk(exp_d.size() == 0 && tx_valid == 1'b0, "R1 drained", 64'(exp_d.size()), 0);
    chk_drops("R8 final");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule